// File: doc/BRIEF.md
# Configurable Set Replacement Selector

This block picks the way to evict from one set of a set-associative cache. For every set it keeps three pieces of replacement state side by side: a binary tree of pseudo-LRU bits, a rotating fill pointer, and a record of the way touched most recently. A two-bit policy select chooses which of them drives the victim output. All three are kept up to date whichever policy is selected, so the select can change between any two cycles and still give a valid choice.

The cache controller drives a set index. It pulses the touch strobe with the way number on every hit and every fill. It pulses the miss strobe when a line is replaced. The victim for the indexed set comes straight out of the current stored state through combinational logic. A strobe applied at one clock edge shows up in the victim from the next cycle onward. The tree state moves on every touch. The rotating pointer moves only on misses. The no-most-recent policy reads both the pointer and the recent-way record.

The state machine for the policy select has four named states. TREE is code 00. ROUND is code 01. SKIPMRU is code 10. SPARE is code 11, which behaves like ROUND. The select is not registered, so each transition (TREE to ROUND, ROUND to SKIPMRU, and every other pairing) takes effect in the same cycle the code changes.

Top module: `way_evict_picker`

## Requirements
- R1: After reset every set has all tree bits, its pointer and its recent-way record at zero. The victim for any set is therefore way 0 under TREE (00), ROUND (01) and SPARE (11), and way 1 under SKIPMRU (10).
- R2: Under TREE the victim is found by walking the tree from the root. Node n has children 2n+1 and 2n+2. A node bit of 1 selects the upper half of the ways. The bits read from root to leaf form the victim number, most significant bit first.
- R3: A touch of way w sets each node on w's path so that it points away from w. This happens on hits and fills alike. Right after a touch of w, the TREE victim for that set is not w.
- R4: Under ROUND the victim equals the set's pointer. The pointer advances by one modulo WAYS on each miss, so it wraps from WAYS-1 to 0. It does not move on a cycle without a miss.
- R5: Under SKIPMRU the victim is the pointer, unless the pointer equals the recent-way record. In that case the victim is the pointer plus one modulo WAYS. The victim never equals the recent-way record.
- R6: Each touch stores the touched way as the set's recent-way record.
- R7: A strobe changes only the state of the set named by set_idx in that cycle. Every other set keeps its state.
- R8: The SPARE code (11) selects the same victim as ROUND. Tree, pointer and recent-way state are maintained under every policy code.
- R9: The victim is combinational. A change of set_idx or policy changes it within the same cycle. A strobe takes effect in the cycle after the clock edge that samples it.
- R10: A miss without a touch leaves the tree bits and the recent-way record unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx | input | $clog2(SETS) | Set being accessed and queried |
| touch_valid | input | 1 | Strobe: a way of the set was accessed (hit or fill) |
| touch_way | input | $clog2(WAYS) | Way that was accessed |
| miss | input | 1 | Strobe: a replacement happened in the set |
| policy | input | 2 | 00 TREE, 01 ROUND, 10 SKIPMRU, 11 SPARE |
| victim | output | $clog2(WAYS) | Way to evict from the indexed set |

## Verification
A wrong tree bit shows up as a wrong TREE victim the first time its set is queried under that policy. Since the victim is combinational, this happens in the same cycle as the query. A pointer that moved on a plain touch, or failed to move on a miss, makes the ROUND and SKIPMRU victims disagree with the model on the very next query of that set. A lost or misrouted recent-way record shows only under SKIPMRU, and only once the pointer reaches that way, so the stimulus drives long runs of misses on a few sets to bring the pointer round. A write that leaks into a neighbouring set is caught when that set is next queried, which random indexing over all sets makes happen soon.

// File: rtl/evict_pkg.sv
package evict_pkg;

    typedef enum logic [1:0] {
        POL_TREE    = 2'b00,
        POL_ROUND   = 2'b01,
        POL_SKIPMRU = 2'b10,
        POL_SPARE   = 2'b11
    } policy_e;

endpackage

// File: rtl/evict_tree_store.sv
module evict_tree_store #(
    parameter int WAYS = 4,
    parameter int SETS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] rd_idx,
    input  logic                    touch_valid,
    input  logic [$clog2(WAYS)-1:0] touch_way,
    output logic [$clog2(WAYS)-1:0] victim_o
);
    localparam int WW    = $clog2(WAYS);
    localparam int IDXW  = $clog2(SETS);
    localparam int NODES = WAYS - 1;
    localparam int NIW   = $clog2(NODES);

    logic [NODES-1:0] tree_q [SETS];
    logic [NODES-1:0] cur_bits;
    logic [NODES-1:0] tree_nxt;

    assign cur_bits = tree_q[rd_idx];

    // Path update: each node on the way's path points away from it
    always_comb begin
        int node;
        logic b;
        tree_nxt = cur_bits;
        node = 0;
        for (int lvl = 0; lvl < WW; lvl++) begin
            b = touch_way[WW-1-lvl];
            tree_nxt[node[NIW-1:0]] = ~b;
            node = 2 * node + 1 + int'(b);
        end
    end

    // Victim walk from the root
    always_comb begin
        int node;
        logic b;
        victim_o = '0;
        node = 0;
        for (int lvl = 0; lvl < WW; lvl++) begin
            b = cur_bits[node[NIW-1:0]];
            victim_o[WW-1-lvl] = b;
            node = 2 * node + 1 + int'(b);
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tree_q[s] <= '0;
            end else if (touch_valid && (rd_idx == IDXW'(s))) begin
                tree_q[s] <= tree_nxt;
            end
        end
    end

    // R3
    touch_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |=> ((rd_idx != $past(rd_idx)) || (victim_o != $past(touch_way))));

    // R10
    tree_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_valid |=> (tree_q[$past(rd_idx)] == $past(cur_bits)));

endmodule

// File: rtl/evict_ring_store.sv
module evict_ring_store #(
    parameter int WAYS = 4,
    parameter int SETS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] rd_idx,
    input  logic                    miss,
    output logic [$clog2(WAYS)-1:0] ptr_o
);
    localparam int WW   = $clog2(WAYS);
    localparam int IDXW = $clog2(SETS);

    logic [WW-1:0] ptr_q [SETS];

    assign ptr_o = ptr_q[rd_idx];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q[s] <= '0;
            end else if (miss && (rd_idx == IDXW'(s))) begin
                ptr_q[s] <= ptr_q[s] + WW'(1);
            end
        end
    end

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (ptr_q[$past(rd_idx)] == WW'($past(ptr_o) + WW'(1))));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miss |=> (ptr_q[$past(rd_idx)] == $past(ptr_o)));

endmodule

// File: rtl/evict_mru_store.sv
module evict_mru_store #(
    parameter int WAYS = 4,
    parameter int SETS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] rd_idx,
    input  logic                    touch_valid,
    input  logic [$clog2(WAYS)-1:0] touch_way,
    output logic [$clog2(WAYS)-1:0] mru_o
);
    localparam int WW   = $clog2(WAYS);
    localparam int IDXW = $clog2(SETS);

    logic [WW-1:0] mru_q [SETS];

    assign mru_o = mru_q[rd_idx];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mru_q[s] <= '0;
            end else if (touch_valid && (rd_idx == IDXW'(s))) begin
                mru_q[s] <= touch_way;
            end
        end
    end

    // R6
    mru_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_valid |=> (mru_q[$past(rd_idx)] == $past(touch_way)));

endmodule

// File: rtl/way_evict_picker.sv
module way_evict_picker
    import evict_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] set_idx,
    input  logic                    touch_valid,
    input  logic [$clog2(WAYS)-1:0] touch_way,
    input  logic                    miss,
    input  logic [1:0]              policy,
    output logic [$clog2(WAYS)-1:0] victim
);
    localparam int WW = $clog2(WAYS);

    policy_e       pol;
    logic [WW-1:0] tree_vic;
    logic [WW-1:0] ring_ptr;
    logic [WW-1:0] mru_w;
    logic [WW-1:0] skip_vic;

    assign pol = policy_e'(policy);

    evict_tree_store #(.WAYS(WAYS), .SETS(SETS)) u_tree (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (set_idx),
        .touch_valid (touch_valid),
        .touch_way   (touch_way),
        .victim_o    (tree_vic)
    );

    evict_ring_store #(.WAYS(WAYS), .SETS(SETS)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (set_idx),
        .miss   (miss),
        .ptr_o  (ring_ptr)
    );

    evict_mru_store #(.WAYS(WAYS), .SETS(SETS)) u_mru (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (set_idx),
        .touch_valid (touch_valid),
        .touch_way   (touch_way),
        .mru_o       (mru_w)
    );

    // Rotation skips the most recently used way
    assign skip_vic = (ring_ptr == mru_w) ? (ring_ptr + WW'(1)) : ring_ptr;

    always_comb begin
        unique case (pol)
            POL_TREE:    victim = tree_vic;
            POL_ROUND:   victim = ring_ptr;
            POL_SKIPMRU: victim = skip_vic;
            POL_SPARE:   victim = ring_ptr;
            default:     victim = ring_ptr;
        endcase
    end

    // R5
    skip_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_SKIPMRU) |-> (victim != mru_w));

    // R8
    spare_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_SPARE) |-> (victim == ring_ptr));

endmodule

// File: tb/test_way_evict_picker.sv
module test_way_evict_picker;
    localparam int WAYS  = 4;
    localparam int SETS  = 16;
    localparam int WW    = $clog2(WAYS);
    localparam int IDXW  = $clog2(SETS);
    localparam int NODES = WAYS - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [IDXW-1:0] set_idx = '0;
    logic            touch_valid = 1'b0;
    logic [WW-1:0]   touch_way = '0;
    logic            miss = 1'b0;
    logic [1:0]      policy = 2'b00;
    logic [WW-1:0]   victim;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int m_tree [SETS][NODES];
    int m_ptr  [SETS];
    int m_mru  [SETS];

    always #5 clk = ~clk;

    way_evict_picker #(.WAYS(WAYS), .SETS(SETS)) i_way_evict_picker (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .touch_valid(touch_valid),
        .touch_way(touch_way), .miss(miss), .policy(policy), .victim(victim)
    );

    function automatic int tree_pick(int s);
        int node = 0;
        int v = 0;
        for (int l = 0; l < WW; l++) begin
            int b = m_tree[s][node];
            v = v * 2 + b;
            node = 2 * node + 1 + b;
        end
        return v;
    endfunction

    function automatic int model_victim(int s, int p);
        case (p)
            0: return tree_pick(s);
            2: return (m_ptr[s] == m_mru[s]) ? (m_ptr[s] + 1) % WAYS : m_ptr[s];
            default: return m_ptr[s];
        endcase
    endfunction

    task automatic check(string tag, int s, int p);
        int exp_v = model_victim(s, p);
        tests++;
        if (int'(victim) != exp_v) begin
            fails++;
            $display("FAIL %s set=%0d pol=%0d victim=%0d expected=%0d", tag, s, p, victim, exp_v);
        end
    endtask

    task automatic step(int s, bit tv, int tw, bit ms, int p, string tag);
        @(negedge clk);
        set_idx = IDXW'(s);
        touch_valid = tv;
        touch_way = WW'(tw);
        miss = ms;
        policy = 2'(p);
        #1;
        check(tag, s, p);
        @(posedge clk);
        if (tv) begin
            int node = 0;
            for (int l = 0; l < WW; l++) begin
                int b = (tw >> (WW - 1 - l)) & 1;
                m_tree[s][node] = 1 - b;
                node = 2 * node + 1 + b;
            end
            m_mru[s] = tw;
        end
        if (ms) m_ptr[s] = (m_ptr[s] + 1) % WAYS;
    endtask

    task automatic peek(int s, int p, string tag);
        @(negedge clk);
        set_idx = IDXW'(s);
        policy = 2'(p);
        touch_valid = 1'b0;
        miss = 1'b0;
        #1;
        check(tag, s, p);
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            m_mru[s] = 0;
            for (int n = 0; n < NODES; n++) m_tree[s][n] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state under every policy, all sets
        for (int s = 0; s < SETS; s++)
            for (int p = 0; p < 4; p++) peek(s, p, "R1");

        // R2 / R3: touches walk the tree
        step(3, 1, 0, 0, 0, "R2");
        step(3, 1, 2, 0, 0, "R3");
        step(3, 1, 1, 0, 0, "R3");
        step(3, 1, 3, 0, 0, "R3");
        peek(3, 0, "R2");
        // R4: ptr unchanged by touches, then misses wrap
        peek(3, 1, "R4");
        for (int k = 0; k < 6; k++) step(5, 0, 0, 1, 1, "R4");
        peek(5, 1, "R4");
        // R10: misses left tree and mru of set 5 untouched
        peek(5, 0, "R10");
        peek(5, 2, "R10");
        // R6 / R5: record a way, walk pointer onto it
        step(7, 1, 2, 0, 2, "R6");
        step(7, 0, 0, 1, 2, "R5");
        step(7, 0, 0, 1, 2, "R5");
        peek(7, 2, "R5");
        step(7, 1, 3, 1, 2, "R6");
        peek(7, 2, "R6");
        // R7: other sets kept their state
        peek(4, 0, "R7");
        peek(4, 1, "R7");
        peek(6, 2, "R7");
        // R8: spare code follows round robin
        peek(5, 3, "R8");
        // R9: combinational index and policy change
        peek(3, 0, "R9");
        peek(5, 1, "R9");
        peek(7, 2, "R9");

        // Random traffic, checked every cycle
        for (int k = 0; k < 4000; k++) begin
            int s = $urandom_range(0, SETS - 1);
            int p = $urandom_range(0, 3);
            string tag = (p == 0) ? "R2" : (p == 2) ? "R5" : (p == 3) ? "R8" : "R4";
            step(s, 1'($urandom_range(0, 1)), $urandom_range(0, WAYS - 1),
                 1'($urandom_range(0, 1)), p, tag);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule